// File: doc/BRIEF.md
# Streaming Serial Read Shifter

This block produces the serial data output of a read command in a serial-access EEPROM. When the command decoder has taken in the last address bit of a read, it pulses a start strobe with the start address. The block then fetches the addressed location from a synchronous memory read port and presents one leading zero bit. On each following rising edge of the serial clock it shifts out the data, most significant bit first.

While chip select stays high, the block keeps streaming. After each byte or word it steps the internal address, and it fetches the next location ahead of time so that the following unit follows the last bit of the current one with no gap and no further zero bit. The address wraps to zero after the highest location. A width select chooses 16-bit words or 8-bit bytes. In byte mode the start address has one more bit, and that extra bit picks a half of a memory word. When chip select falls, the output is released and the block goes idle.

The serial clock enters as `sclk_rise`, a pulse lasting one system clock cycle per rising edge, already synchronised to `clk`.

Top module: `mw_read_streamer`

## Requirements
- R1: After reset `so_en`, `so_data` and `mem_ren` are all 0.
- R2: A `rd_start` pulse sampled while `cs` is high makes `so_en` 1 and `so_data` 0 from the next cycle. This leading zero is held until the first `sclk_rise`.
- R3: In word mode (`wide_mode` = 1), each `sclk_rise` presents the next bit of the 16-bit memory word on `so_data`, from bit 15 down to bit 0. The top bit of `rd_addr` is ignored in this mode.
- R4: In byte mode (`wide_mode` = 0), `rd_addr[AW:1]` selects the memory word and `rd_addr[0]` selects the byte. An even address gives bits 15..8 and an odd address gives bits 7..0. Eight bits are shifted out, MSB first.
- R5: While `cs` stays high, the `sclk_rise` after the last bit of a unit presents the MSB of the unit at the next address, with no zero bit in between.
- R6: The address wraps to 0 after the highest location: 2^AW-1 in word mode and 2^(AW+1)-1 in byte mode.
- R7: With `cs` low, `so_en` and `so_data` are 0 from the next cycle. While `cs` stays low, `sclk_rise` issues no memory read and does not enable the output.
- R8: `mem_ren` is 1 with `mem_addr` set to the start word in the cycle an accepted `rd_start` is sampled. It is also 1 with the next unit's word address in the cycle of the `sclk_rise` that presents a unit's MSB. In every other cycle it is 0.
- R9: While `cs` is high, `so_data` changes only in the cycle after a `sclk_rise` or an accepted `rd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| cs | input | 1 | Chip select, active high |
| rd_start | input | 1 | Read start strobe from the command decoder |
| rd_addr | input | AW+1 | Start address (byte address in byte mode) |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| mem_ren | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the request |
| so_data | output | 1 | Serial data output |
| so_en | output | 1 | Output enable; 0 means released |

## Verification
The assertions rely on three properties of the inputs. `rd_start` comes only while `cs` is high. `mem_rdata` arrives one cycle after `mem_ren`. Serial edges are at least two system cycles apart, and the first one comes at least two cycles after the start strobe, so each prefetched unit is in the hold register before it is needed. The bench keeps to these rules by construction: it sends a serial edge every fourth cycle, waits two cycles after each start, and its memory model returns data with exactly one cycle of latency. Start addresses, modes and stream lengths are drawn at random within those rules. Directed runs cover both wrap points and reads with `cs` low.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
    typedef enum logic {
        ORG_BYTE = 1'b0,
        ORG_WORD = 1'b1
    } org_e;
endpackage

// File: rtl/mwr_word_index.sv
module mwr_word_index
    import mwr_pkg::*;
#(
    parameter int AW = 6
) (
    input  org_e          org,
    input  logic [AW:0]   addr_i,
    output logic [AW-1:0] word_o
);
    always_comb begin
        if (org == ORG_WORD) word_o = addr_i[AW-1:0];
        else                 word_o = addr_i[AW:1];
    end
endmodule

// File: rtl/mwr_addr_step.sv
module mwr_addr_step
    import mwr_pkg::*;
#(
    parameter int AW = 6
) (
    input  org_e        org,
    input  logic [AW:0] addr_i,
    output logic [AW:0] addr_o
);
    localparam logic [AW-1:0] WORD_ONE = AW'(1);
    localparam logic [AW:0]   BYTE_ONE = (AW + 1)'(1);

    always_comb begin
        if (org == ORG_WORD) addr_o = {1'b0, addr_i[AW-1:0] + WORD_ONE};
        else                 addr_o = addr_i + BYTE_ONE;
    end
endmodule

// File: rtl/mwr_lane_pick.sv
module mwr_lane_pick
    import mwr_pkg::*;
#(
    parameter int DW = 16
) (
    input  org_e          org,
    input  logic          odd,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] aligned_o
);
    localparam int HW = DW / 2;

    always_comb begin
        if (org == ORG_WORD) aligned_o = word_i;
        else if (odd)        aligned_o = {word_i[HW-1:0], {HW{1'b0}}};
        else                 aligned_o = {word_i[DW-1:HW], {HW{1'b0}}};
    end
endmodule

// File: rtl/mw_read_streamer.sv
module mw_read_streamer
    import mwr_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          cs,
    input  logic          rd_start,
    input  logic [AW:0]   rd_addr,
    input  logic          wide_mode,
    output logic          mem_ren,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          so_data,
    output logic          so_en
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST_WORD = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_BYTE = CW'(HW - 1);

    typedef struct packed {
        logic          act;
        org_e          org;
        logic          pend;
        logic [AW:0]   addr;
        logic [DW-1:0] hold;
        logic [DW-1:0] sh;
        logic [CW-1:0] left;
    } st_t;

    st_t st_d, st_q;

    org_e          start_org;
    logic [AW-1:0] start_word;
    logic [AW:0]   step_addr;
    logic [AW-1:0] step_word;
    logic [DW-1:0] aligned;

    assign start_org = wide_mode ? ORG_WORD : ORG_BYTE;

    mwr_word_index #(.AW(AW)) u_idx_start (
        .org    (start_org),
        .addr_i (rd_addr),
        .word_o (start_word)
    );

    mwr_addr_step #(.AW(AW)) u_step (
        .org    (st_q.org),
        .addr_i (st_q.addr),
        .addr_o (step_addr)
    );

    mwr_word_index #(.AW(AW)) u_idx_next (
        .org    (st_q.org),
        .addr_i (step_addr),
        .word_o (step_word)
    );

    mwr_lane_pick #(.DW(DW)) u_pick (
        .org       (st_q.org),
        .odd       (st_q.addr[0]),
        .word_i    (st_q.hold),
        .aligned_o (aligned)
    );

    always_comb begin
        st_d     = st_q;
        mem_ren  = 1'b0;
        mem_addr = step_word;
        if (st_q.pend) begin
            st_d.hold = mem_rdata;
            st_d.pend = 1'b0;
        end
        if (!cs) begin
            st_d.act = 1'b0;
        end else if (rd_start) begin
            st_d.act  = 1'b1;
            st_d.org  = start_org;
            st_d.addr = rd_addr;
            st_d.sh   = '0;
            st_d.left = '0;
            st_d.pend = 1'b1;
            mem_ren   = 1'b1;
            mem_addr  = start_word;
        end else if (st_q.act && sclk_rise) begin
            if (st_q.left == '0) begin
                st_d.sh   = aligned;
                st_d.left = (st_q.org == ORG_WORD) ? LAST_WORD : LAST_BYTE;
                st_d.addr = step_addr;
                st_d.pend = 1'b1;
                mem_ren   = 1'b1;
                mem_addr  = step_word;
            end else begin
                st_d.sh   = {st_q.sh[DW-2:0], 1'b0};
                st_d.left = st_q.left - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: 1'b0, org: ORG_WORD, pend: 1'b0, addr: '0,
                      hold: '0, sh: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign so_en   = st_q.act;
    assign so_data = st_q.act & st_q.sh[DW-1];
endmodule

// File: rtl/mw_read_streamer_chk.sv
module mw_read_streamer_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_rise,
    input logic cs,
    input logic rd_start,
    input logic mem_ren,
    input logic so_data,
    input logic so_en
);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!so_en && !so_data));

    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_start) |=> (so_en && !so_data));

    assert_enable_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(cs && rd_start));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !rd_start && !sclk_rise) |=> $stable(so_data));

    assert_fetch_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ren |-> (cs && (rd_start || sclk_rise)));
endmodule

bind mw_read_streamer mw_read_streamer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .cs        (cs),
    .rd_start  (rd_start),
    .mem_ren   (mem_ren),
    .so_data   (so_data),
    .so_en     (so_en)
);

// File: tb/mw_read_streamer_test.sv
module mw_read_streamer_test;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk_rise = 1'b0;
    logic          cs = 1'b0;
    logic          rd_start = 1'b0;
    logic [AW:0]   rd_addr = '0;
    logic          wide_mode = 1'b1;
    logic          mem_ren;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          so_data;
    logic          so_en;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (mem_ren) rd_q <= mem[mem_addr];
    assign mem_rdata = rd_q;

    mw_read_streamer #(.AW(AW), .DW(DW)) uut (
        .clk, .rst_n, .sclk_rise, .cs, .rd_start, .rd_addr, .wide_mode,
        .mem_ren, .mem_addr, .mem_rdata, .so_data, .so_en
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int span_of(input bit wide);
        return wide ? DEPTH : 2 * DEPTH;
    endfunction

    function automatic int word_of(input int a, input bit wide);
        return wide ? (a % DEPTH) : ((a % (2 * DEPTH)) >> 1);
    endfunction

    function automatic logic exp_bit(input int a, input bit wide, input int k);
        logic [DW-1:0] w;
        logic [7:0]    b;
        w = mem[word_of(a, wide)];
        if (wide) return w[DW-1-k];
        b = a[0] ? w[7:0] : w[15:8];
        return b[7-k];
    endfunction

    task automatic begin_read(input int start, input bit wide);
        cs        = 1'b1;
        wide_mode = wide;
        rd_addr   = start[AW:0];
        rd_start  = 1'b1;
        #1;
        chk(mem_ren === 1'b1 && mem_addr === AW'(word_of(start, wide)), "R8",
            {mem_ren, mem_addr}, {1'b1, AW'(word_of(start, wide))});
        @(negedge clk);
        rd_start = 1'b0;
        chk(so_en === 1'b1 && so_data === 1'b0, "R2", {so_en, so_data}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        chk(so_data === 1'b0, "R2", so_data, 0);
    endtask

    task automatic run_read(input int start, input bit wide, input int nwords);
        int span;
        int nbits;
        span  = span_of(wide);
        nbits = wide ? DW : DW / 2;
        begin_read(start, wide);
        for (int w = 0; w < nwords; w++) begin
            int    a;
            int    nxt;
            string tag;
            a   = (start % span + w) % span;
            nxt = (a + 1) % span;
            if ((start % span + w) >= span) tag = "R6";
            else if (w > 0)                 tag = "R5";
            else                            tag = wide ? "R3" : "R4";
            for (int k = 0; k < nbits; k++) begin
                logic e;
                logic held;
                sclk_rise = 1'b1;
                #1;
                if (k == 0)
                    chk(mem_ren === 1'b1 && mem_addr === AW'(word_of(nxt, wide)), "R8",
                        {mem_ren, mem_addr}, {1'b1, AW'(word_of(nxt, wide))});
                else
                    chk(mem_ren === 1'b0, "R8", mem_ren, 0);
                @(negedge clk);
                sclk_rise = 1'b0;
                e = exp_bit(a, wide, k);
                chk(so_data === e, tag, so_data, e);
                held = so_data;
                @(negedge clk);
                @(negedge clk);
                chk(so_data === held, "R9", so_data, held);
                @(negedge clk);
            end
        end
        cs = 1'b0;
        @(negedge clk);
        chk(so_en === 1'b0 && so_data === 1'b0, "R7", {so_en, so_data}, 0);
        sclk_rise = 1'b1;
        #1;
        chk(mem_ren === 1'b0, "R7", mem_ren, 0);
        @(negedge clk);
        sclk_rise = 1'b0;
        chk(so_en === 1'b0, "R7", so_en, 0);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0b17);
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
        mem[0] = 16'hA5C3;
        repeat (3) @(negedge clk);
        chk(so_en === 1'b0 && so_data === 1'b0 && mem_ren === 1'b0, "R1",
            {so_en, so_data, mem_ren}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(so_en === 1'b0 && mem_ren === 1'b0, "R1", {so_en, mem_ren}, 0);
        run_read(5, 1'b1, 2);
        run_read(DEPTH + 9, 1'b1, 1);
        run_read(6, 1'b0, 2);
        run_read(11, 1'b0, 2);
        run_read(DEPTH - 1, 1'b1, 3);
        run_read(2 * DEPTH - 2, 1'b0, 4);
        for (int r = 0; r < 6; r++) begin
            int a;
            bit wd;
            int n;
            a  = int'($urandom_range(2 * DEPTH - 1, 0));
            wd = 1'($urandom_range(1, 0));
            n  = int'($urandom_range(3, 1));
            run_read(a, wd, n);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule